// File: doc/BRIEF.md
# Two-Port Hardware Semaphore Bank

This block holds a small set of hardware lock flags that two independent agents, a left port and a right port, use to coordinate ownership of shared resources. Each port selects one flag with a short address and either asks for it, by writing 0 on data bit 0, or gives it up, by writing 1. Reading a flag returns that port's own view of it, copied onto every data bit. A port sees 0 while it holds the token. It sees 1 when the flag is free or when the other port holds it.

A port reaches the bank only while its semaphore select is high and its memory enable is low. A request that arrives while the other port holds the token is not dropped. It is stored, and it turns into ownership in the same clock edge at which the holder releases. A port can cancel its own stored request by writing 1. If both ports ask for a free flag in the same cycle, the left port gets it and the right request is stored.

All state changes happen on the rising clock edge. Read data is combinational from the current state, so the effect of a write is visible from the cycle after that write.

Top module: `sem_bank`

## Requirements
- R1: After reset every flag is free, and both ports read 8'hFF from every address.
- R2: A port accesses the bank only while its select is 1 and its memory enable is 0. Writes outside that condition change no flag, and read data is 8'h00 while the port is not accessing.
- R3: The three low address bits pick one of eight independent flags. A write acts on data bit 0 only, so 8'hFE is a request and 8'h01 is a release. Read data carries the port's view bit on all eight bits, 8'h00 or 8'hFF.
- R4: A port that writes 0 to a free flag takes the token. Afterwards that port reads 8'h00 and the other port reads 8'hFF. The two ports never both read 8'h00 from the same flag.
- R5: A port that writes 0 while the other port holds the token leaves the ownership unchanged, and its request is stored as pending.
- R6: When the holder writes 1 while the other port has a pending request, or is requesting in that same cycle, the token passes to the other port.
- R7: When the holder writes 1 and no request from the other port is pending, the flag becomes free.
- R8: A 1 written by the port that does not hold the token leaves the ownership unchanged and cancels that port's own pending request, so a later release by the holder frees the flag.
- R9: When both ports write 0 to a free flag in the same cycle, the left port takes the token and the right request is stored as pending.
- R10: A 0 written by the port that already holds the token has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| l_mem_en | input | 1 | Left memory enable, must be 0 for a bank access |
| l_sem_sel | input | 1 | Left semaphore select, 1 for a bank access |
| l_wr | input | 1 | Left write strobe |
| l_addr | input | 3 | Left flag address |
| l_wdata | input | 8 | Left write data, bit 0 is used |
| l_rdata | output | 8 | Left read data, replicated view bit |
| r_mem_en | input | 1 | Right memory enable, must be 0 for a bank access |
| r_sem_sel | input | 1 | Right semaphore select, 1 for a bank access |
| r_wr | input | 1 | Right write strobe |
| r_addr | input | 3 | Right flag address |
| r_wdata | input | 8 | Right write data, bit 0 is used |
| r_rdata | output | 8 | Right read data, replicated view bit |

## Verification
A flag whose owner state is wrong shows up at the very next read of that address. It either reads 8'h00 on both ports, or one port reads 8'h00 when the other should. A lost or stale pending bit stays hidden until the holder releases. At that point the flag either becomes free when it should have been handed over, or is handed to a port that had cancelled its request, so the error appears one cycle after the release write. Because of this delay, the bench reads every flag on both ports after every cycle. That way a hidden error is caught at the first cycle where it changes the view.

// File: rtl/sem_pkg.sv
package sem_pkg;
   typedef enum logic [1:0] {
      OWN_NONE  = 2'd0,
      OWN_LEFT  = 2'd1,
      OWN_RIGHT = 2'd2
   } owner_t;
endpackage

// File: rtl/sem_port_decode.sv
module sem_port_decode #(
   parameter int NUM_FLAGS = 8,
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 8
) (
   input  logic                 mem_en,
   input  logic                 sem_sel,
   input  logic                 wr,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [DATA_W-1:0]    wdata,
   output logic                 access,
   output logic [NUM_FLAGS-1:0] take_vec,
   output logic [NUM_FLAGS-1:0] drop_vec
);
   logic wr_ok;
   logic unused_hi_bits;

   assign access         = sem_sel & ~mem_en;
   assign wr_ok          = access & wr;
   assign unused_hi_bits = ^wdata[DATA_W-1:1];

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_dec
      localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
      assign take_vec[i] = wr_ok & (addr == IDX) & ~wdata[0];
      assign drop_vec[i] = wr_ok & (addr == IDX) &  wdata[0];
   end
endmodule

// File: rtl/sem_flag_cell.sv
module sem_flag_cell
   import sem_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic l_take,
   input  logic l_drop,
   input  logic r_take,
   input  logic r_drop,
   output logic l_view,
   output logic r_view
);
   owner_t own_q, own_d;
   logic   pl_q, pl_d, pr_q, pr_d;
   logic   pl_req, pr_req;

   always_comb begin
      own_d  = own_q;
      pl_d   = pl_q;
      pr_d   = pr_q;
      pl_req = (pl_q | l_take) & ~l_drop;
      pr_req = (pr_q | r_take) & ~r_drop;
      case (own_q)
         OWN_NONE: begin
            pl_d = 1'b0;
            pr_d = 1'b0;
            if (l_take) begin
               own_d = OWN_LEFT;
               pr_d  = r_take;
            end else if (r_take) begin
               own_d = OWN_RIGHT;
            end
         end
         OWN_LEFT: begin
            pl_d = 1'b0;
            if (l_drop) begin
               pr_d  = 1'b0;
               own_d = pr_req ? OWN_RIGHT : OWN_NONE;
            end else begin
               pr_d = pr_req;
            end
         end
         OWN_RIGHT: begin
            pr_d = 1'b0;
            if (r_drop) begin
               pl_d  = 1'b0;
               own_d = pl_req ? OWN_LEFT : OWN_NONE;
            end else begin
               pl_d = pl_req;
            end
         end
         default: begin
            own_d = OWN_NONE;
            pl_d  = 1'b0;
            pr_d  = 1'b0;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         own_q <= OWN_NONE;
         pl_q  <= 1'b0;
         pr_q  <= 1'b0;
      end else begin
         own_q <= own_d;
         pl_q  <= pl_d;
         pr_q  <= pr_d;
      end
   end

   assign l_view = (own_q != OWN_LEFT);
   assign r_view = (own_q != OWN_RIGHT);

   AST_FREE_NO_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_NONE) |-> (!pl_q && !pr_q)); // R7
   AST_TIE_LEFT_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_NONE && l_take && r_take) |=> (own_q == OWN_LEFT && pr_q)); // R9
   AST_CONTEND_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_LEFT && r_take && !l_drop) |=> (own_q == OWN_LEFT && pr_q)); // R5
   AST_HANDOFF: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_LEFT && l_drop && pr_q && !r_drop) |=> (own_q == OWN_RIGHT)); // R6
   AST_RELEASE_FREE: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_RIGHT && r_drop && !pl_q && !l_take) |=> (own_q == OWN_NONE)); // R7
   AST_FOREIGN_DROP: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_LEFT && r_drop && !l_drop) |=> (own_q == OWN_LEFT && !pr_q)); // R8
   AST_RETAKE_NOOP: assert property (@(posedge clk) disable iff (!rst_n)
      (own_q == OWN_RIGHT && r_take) |=> (own_q == OWN_RIGHT)); // R10
endmodule

// File: rtl/sem_read_mux.sv
module sem_read_mux #(
   parameter int NUM_FLAGS = 8,
   parameter int ADDR_W    = 3,
   parameter int DATA_W    = 8
) (
   input  logic                 access,
   input  logic [ADDR_W-1:0]    addr,
   input  logic [NUM_FLAGS-1:0] view_vec,
   output logic [DATA_W-1:0]    rdata
);
   assign rdata = access ? {DATA_W{view_vec[addr]}} : '0;
endmodule

// File: rtl/sem_bank.sv
module sem_bank #(
   parameter int NUM_FLAGS = 8,
   parameter int DATA_W    = 8,
   localparam int ADDR_W   = $clog2(NUM_FLAGS)
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              l_mem_en,
   input  logic              l_sem_sel,
   input  logic              l_wr,
   input  logic [ADDR_W-1:0] l_addr,
   input  logic [DATA_W-1:0] l_wdata,
   output logic [DATA_W-1:0] l_rdata,
   input  logic              r_mem_en,
   input  logic              r_sem_sel,
   input  logic              r_wr,
   input  logic [ADDR_W-1:0] r_addr,
   input  logic [DATA_W-1:0] r_wdata,
   output logic [DATA_W-1:0] r_rdata
);
   if (NUM_FLAGS < 2 || (NUM_FLAGS & (NUM_FLAGS - 1)) != 0) begin : g_bad_flags
      $error("sem_bank: NUM_FLAGS must be a power of two and at least 2");
   end
   if (DATA_W < 2) begin : g_bad_width
      $error("sem_bank: DATA_W must be at least 2");
   end

   logic                 l_acc, r_acc;
   logic [NUM_FLAGS-1:0] l_take, l_drop, r_take, r_drop;
   logic [NUM_FLAGS-1:0] l_view, r_view;

   sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_l (
      .mem_en(l_mem_en), .sem_sel(l_sem_sel), .wr(l_wr), .addr(l_addr), .wdata(l_wdata),
      .access(l_acc), .take_vec(l_take), .drop_vec(l_drop));

   sem_port_decode #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dec_r (
      .mem_en(r_mem_en), .sem_sel(r_sem_sel), .wr(r_wr), .addr(r_addr), .wdata(r_wdata),
      .access(r_acc), .take_vec(r_take), .drop_vec(r_drop));

   for (genvar i = 0; i < NUM_FLAGS; i++) begin : g_flag
      sem_flag_cell u_cell (
         .clk(clk), .rst_n(rst_n),
         .l_take(l_take[i]), .l_drop(l_drop[i]),
         .r_take(r_take[i]), .r_drop(r_drop[i]),
         .l_view(l_view[i]), .r_view(r_view[i]));

      AST_VIEW_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
         (l_view[i] || r_view[i])); // R4
   end

   sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_l (
      .access(l_acc), .addr(l_addr), .view_vec(l_view), .rdata(l_rdata));

   sem_read_mux #(.NUM_FLAGS(NUM_FLAGS), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rd_r (
      .access(r_acc), .addr(r_addr), .view_vec(r_view), .rdata(r_rdata));

   AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      (!l_acc || l_mem_en) |-> (l_rdata == '0)); // R2
   AST_GATED_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
      (l_mem_en && r_mem_en) |=> ($stable(l_view) && $stable(r_view))); // R2
   AST_READ_REPLICATED: assert property (@(posedge clk) disable iff (!rst_n)
      r_acc |-> (r_rdata == '0 || r_rdata == '1)); // R3
endmodule

// File: tb/sem_bank_bench.sv
`timescale 1ns/100ps
module sem_bank_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       l_mem_en = 1'b0, l_sem_sel = 1'b0, l_wr = 1'b0;
   logic [2:0] l_addr = '0;
   logic [7:0] l_wdata = '0;
   logic [7:0] l_rdata;
   logic       r_mem_en = 1'b0, r_sem_sel = 1'b0, r_wr = 1'b0;
   logic [2:0] r_addr = '0;
   logic [7:0] r_wdata = '0;
   logic [7:0] r_rdata;

   int checks = 0;
   int errors = 0;
   bit done = 0;

   int own [8];
   bit pl  [8];
   bit pr  [8];

   always #2.5 clk = ~clk;

   sem_bank u_sem_bank (
      .clk(clk), .rst_n(rst_n),
      .l_mem_en(l_mem_en), .l_sem_sel(l_sem_sel), .l_wr(l_wr),
      .l_addr(l_addr), .l_wdata(l_wdata), .l_rdata(l_rdata),
      .r_mem_en(r_mem_en), .r_sem_sel(r_sem_sel), .r_wr(r_wr),
      .r_addr(r_addr), .r_wdata(r_wdata), .r_rdata(r_rdata));

   function automatic logic [7:0] exp_view(bit right, int a);
      if (right) return (own[a] == 2) ? 8'h00 : 8'hFF;
      return (own[a] == 1) ? 8'h00 : 8'hFF;
   endfunction

   task automatic model_reset();
      for (int i = 0; i < 8; i++) begin
         own[i] = 0; pl[i] = 0; pr[i] = 0;
      end
   endtask

   task automatic model_step(bit lw, int la, bit ld, bit rw, int ra, bit rd);
      for (int i = 0; i < 8; i++) begin
         bit lt, lr, rt, rr, lq, rq;
         lt = lw && la == i && !ld;
         lr = lw && la == i && ld;
         rt = rw && ra == i && !rd;
         rr = rw && ra == i && rd;
         lq = (pl[i] || lt) && !lr;
         rq = (pr[i] || rt) && !rr;
         if (own[i] == 0) begin
            pl[i] = 0; pr[i] = 0;
            if (lt) begin own[i] = 1; pr[i] = rt; end
            else if (rt) own[i] = 2;
         end else if (own[i] == 1) begin
            pl[i] = 0;
            if (lr) begin own[i] = rq ? 2 : 0; pr[i] = 0; end
            else pr[i] = rq;
         end else begin
            pr[i] = 0;
            if (rr) begin own[i] = lq ? 1 : 0; pl[i] = 0; end
            else pl[i] = lq;
         end
      end
   endtask

   task automatic cyc(bit lme, bit lsel, bit lwr, int la, logic [7:0] ld,
                      bit rme, bit rsel, bit rwr, int ra, logic [7:0] rd);
      @(negedge clk);
      l_mem_en = lme; l_sem_sel = lsel; l_wr = lwr; l_addr = 3'(la); l_wdata = ld;
      r_mem_en = rme; r_sem_sel = rsel; r_wr = rwr; r_addr = 3'(ra); r_wdata = rd;
      @(posedge clk);
      model_step(lsel && !lme && lwr, la, ld[0], rsel && !rme && rwr, ra, rd[0]);
      @(negedge clk);
      l_wr = 0; r_wr = 0; l_sem_sel = 0; r_sem_sel = 0; l_mem_en = 0; r_mem_en = 0;
   endtask

   task automatic lw(int a, logic [7:0] d);
      cyc(0, 1, 1, a, d, 0, 0, 0, 0, 8'h00);
   endtask
   task automatic rw(int a, logic [7:0] d);
      cyc(0, 0, 0, 0, 8'h00, 0, 1, 1, a, d);
   endtask

   task automatic cmp(string tag, string who, logic [7:0] act, logic [7:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", tag, who, act, exp);
      end
   endtask

   task automatic chk(string tag, int a, logic [7:0] el, logic [7:0] er);
      l_mem_en = 0; r_mem_en = 0; l_sem_sel = 1; r_sem_sel = 1; l_wr = 0; r_wr = 0;
      l_addr = 3'(a); r_addr = 3'(a);
      #0.2;
      cmp(tag, "left", l_rdata, el);
      cmp(tag, "right", r_rdata, er);
      l_sem_sel = 0; r_sem_sel = 0;
   endtask

   task automatic chk_model(string tag);
      for (int a = 0; a < 8; a++) chk(tag, a, exp_view(0, a), exp_view(1, a));
   endtask

   initial begin
      #(200000 * 5);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7331));
      model_reset();
      repeat (3) @(posedge clk);
      @(negedge clk); rst_n = 1;
      @(negedge clk);
      for (int a = 0; a < 8; a++) chk("R1", a, 8'hFF, 8'hFF);

      // R2: gated read and gated writes
      l_mem_en = 1; l_sem_sel = 1; l_addr = 0; r_sem_sel = 0; r_addr = 0;
      #0.2;
      cmp("R2", "left memen read", l_rdata, 8'h00);
      cmp("R2", "right unselected read", r_rdata, 8'h00);
      cyc(1, 1, 1, 0, 8'h00, 0, 0, 1, 0, 8'h00);
      chk("R2", 0, 8'hFF, 8'hFF);

      // R4 take, R3 independence
      lw(2, 8'h00);
      chk("R4", 2, 8'h00, 8'hFF);
      chk("R3", 3, 8'hFF, 8'hFF);
      lw(2, 8'h00);
      chk("R10", 2, 8'h00, 8'hFF);
      rw(2, 8'h00);
      chk("R5", 2, 8'h00, 8'hFF);
      lw(2, 8'h01);
      chk("R6", 2, 8'hFF, 8'h00);
      rw(2, 8'h01);
      chk("R7", 2, 8'hFF, 8'hFF);

      // R8 foreign release and withdrawal
      rw(5, 8'h00);
      lw(5, 8'h01);
      chk("R8", 5, 8'hFF, 8'h00);
      lw(5, 8'h00);
      lw(5, 8'h01);
      rw(5, 8'h01);
      chk("R8", 5, 8'hFF, 8'hFF);

      // R9 simultaneous request
      cyc(0, 1, 1, 7, 8'h00, 0, 1, 1, 7, 8'h00);
      chk("R9", 7, 8'h00, 8'hFF);
      lw(7, 8'h01);
      chk("R9", 7, 8'hFF, 8'h00);
      rw(7, 8'h01);
      chk("R9", 7, 8'hFF, 8'hFF);

      // R6 handoff with request in release cycle
      lw(4, 8'h00);
      cyc(0, 1, 1, 4, 8'h01, 0, 1, 1, 4, 8'h00);
      chk("R6", 4, 8'hFF, 8'h00);
      rw(4, 8'h01);

      // R3 only bit 0 of write data
      rw(1, 8'hFE);
      chk("R3", 1, 8'hFF, 8'h00);
      rw(1, 8'h01);
      chk("R3", 1, 8'hFF, 8'hFF);
      chk_model("R3");

      // random traffic
      for (int n = 0; n < 800; n++) begin
         bit lme, lsel, lwr, rme, rsel, rwr;
         int la, ra;
         logic [7:0] ld, rd;
         lme = ($urandom % 8) == 0;  lsel = ($urandom % 8) != 0; lwr = $urandom % 2;
         rme = ($urandom % 8) == 0;  rsel = ($urandom % 8) != 0; rwr = $urandom % 2;
         la = ($urandom % 2) ? ($urandom % 2) : ($urandom % 8);
         ra = ($urandom % 2) ? ($urandom % 2) : ($urandom % 8);
         ld = 8'($urandom); rd = 8'($urandom);
         cyc(lme, lsel, lwr, la, ld, rme, rsel, rwr, ra, rd);
         chk_model("R5");
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule